// File: doc/BRIEF.md
# Dual-Channel Compare Flag Unit

This block watches a free-running timer count and reports when it equals either of two programmable compare values. Each channel holds its own compare register. An equality comparator drives a combinational match strobe, which a separate waveform stage can use. A registered compare flag records that a match happened. The flag takes effect on the timer tick that follows the match, not in the cycle of the match itself.

A flag drives that channel's interrupt request when the channel's interrupt enable is set. A flag can be cleared in two ways. The interrupt controller can return an acknowledge pulse when it services the request. Software can also write a one to that flag's bit; writing a zero leaves the flag alone. If a set and a clear arrive in the same cycle, the set wins, so a match is never lost.

Top module: `cmpflag_unit`

## Requirements
- R1: A synchronous active-high reset sets both compare values, both flags, both interrupt enables and all pending match state to zero.
- R2: A pulse on `cmp_wr[i]` (bit 0 = channel A, bit 1 = channel B) loads `cmp_wdata` into channel i's compare register, visible from the next cycle. Both channels may be loaded in the same cycle.
- R3: `match_o[i]` is high in exactly those cycles where `cnt_in` equals channel i's current compare value, with no register delay.
- R4: A match seen in some cycle sets that channel's flag at the end of the first later cycle with `tick_en` high. The flag reads high from the cycle after that tick.
- R5: A match that occurs in a cycle where `tick_en` is itself high does not set the flag at that tick; it sets it at the next tick.
- R6: While `tick_en` stays low, no flag becomes set, however many matches occur.
- R7: `irq_o[i]` is high exactly when flag i and interrupt enable i are both set. A pulse on `ien_wr` loads `ien_wdata` into the enables (bit 0 = A, bit 1 = B).
- R8: A pulse on `irq_ack[i]` clears flag i, effective the next cycle.
- R9: A pulse on `fclr_wr` clears flag i wherever `fclr_wdata[i]` is one; a zero bit leaves that flag unchanged.
- R10: If a flag set (R4) and a clear (R8 or R9) fall in the same cycle for one channel, the flag ends up set.
- R11: The two channels are independent: a match, a clear or an acknowledge on one channel never changes the other channel's flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_in | input | 8 | Running timer count |
| tick_en | input | 1 | Timer tick enable, one cycle per tick |
| cmp_wr | input | 2 | Per-channel compare register write strobes |
| cmp_wdata | input | 8 | Compare register write data |
| ien_wr | input | 1 | Interrupt enable write strobe |
| ien_wdata | input | 2 | Interrupt enable write data |
| irq_ack | input | 2 | Per-channel interrupt acknowledge pulses |
| fclr_wr | input | 1 | Flag clear write strobe |
| fclr_wdata | input | 2 | Flag clear mask, one clears |
| cmp_val_o | output | 16 | Compare values, channel A in bits 7:0, B in bits 15:8 |
| match_o | output | 2 | Combinational match strobes |
| flag_o | output | 2 | Compare flags |
| irq_o | output | 2 | Interrupt requests |

## Verification
Setting a flag on a tick can collide in one cycle with either clear path, the acknowledge pulse or the software write of one. The bench sets up a pending match with the tick held low, then raises the tick in the same cycle as an acknowledge on that channel. It expects the flag to read set afterwards, and it also checks that the next acknowledge, given alone, clears the flag. A match that falls in a tick cycle is a second overlap. The bench checks that the flag stays clear after that tick and becomes set only at the following tick.

// File: rtl/cmpflag_pkg.sv
package cmpflag_pkg;

    localparam int CNT_W  = 8;
    localparam int NUM_CH = 2;

    // per-channel sequential state of the flag path
    typedef struct packed {
        logic pend;   // match observed since the last tick
        logic flag;   // architectural compare flag
    } flag_st_t;

    // one step of the flag path; a set outranks any clear
    function automatic flag_st_t flag_step(
        input flag_st_t cur,
        input logic     tick,
        input logic     match,
        input logic     clr
    );
        flag_st_t nx;
        nx.pend = tick ? match : (cur.pend | match);
        if (tick && cur.pend)
            nx.flag = 1'b1;
        else if (clr)
            nx.flag = 1'b0;
        else
            nx.flag = cur.flag;
        return nx;
    endfunction

endpackage

// File: rtl/cmpflag_cmp_reg.sv
module cmpflag_cmp_reg #(
    parameter int CNT_W = cmpflag_pkg::CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [CNT_W-1:0] wdata,
    input  logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] val_o,
    output logic             match_o
);

    logic [CNT_W-1:0] val_q;

    always_ff @(posedge clk) begin
        if (rst)
            val_q <= '0;
        else if (wr)
            val_q <= wdata;
    end

    assign val_o   = val_q;
    assign match_o = (cnt == val_q);

endmodule

// File: rtl/cmpflag_flag_ctl.sv
module cmpflag_flag_ctl
    import cmpflag_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic match,
    input  logic ack,
    input  logic sw_clr,
    output logic flag_o
);

    flag_st_t st_q;
    flag_st_t st_d;
    logic     clr_any;

    assign clr_any = ack | sw_clr;

    always_comb begin
        st_d = flag_step(st_q, tick, match, clr_any);
    end

    always_ff @(posedge clk) begin
        if (rst)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign flag_o = st_q.flag;

endmodule

// File: rtl/cmpflag_unit.sv
module cmpflag_unit #(
    parameter int CNT_W  = cmpflag_pkg::CNT_W,
    parameter int NUM_CH = cmpflag_pkg::NUM_CH
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [CNT_W-1:0]        cnt_in,
    input  logic                    tick_en,
    input  logic [NUM_CH-1:0]       cmp_wr,
    input  logic [CNT_W-1:0]        cmp_wdata,
    input  logic                    ien_wr,
    input  logic [NUM_CH-1:0]       ien_wdata,
    input  logic [NUM_CH-1:0]       irq_ack,
    input  logic                    fclr_wr,
    input  logic [NUM_CH-1:0]       fclr_wdata,
    output logic [NUM_CH*CNT_W-1:0] cmp_val_o,
    output logic [NUM_CH-1:0]       match_o,
    output logic [NUM_CH-1:0]       flag_o,
    output logic [NUM_CH-1:0]       irq_o
);

    localparam int VAL_W = NUM_CH * CNT_W;

    logic [NUM_CH-1:0] ien_q;
    logic [NUM_CH-1:0] sw_clr;

    always_ff @(posedge clk) begin
        if (rst)
            ien_q <= '0;
        else if (ien_wr)
            ien_q <= ien_wdata;
    end

    assign sw_clr = fclr_wr ? fclr_wdata : '0;

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        cmpflag_cmp_reg #(.CNT_W(CNT_W)) cmp_i (
            .clk     (clk),
            .rst     (rst),
            .wr      (cmp_wr[ch]),
            .wdata   (cmp_wdata),
            .cnt     (cnt_in),
            .val_o   (cmp_val_o[ch*CNT_W +: CNT_W]),
            .match_o (match_o[ch])
        );

        cmpflag_flag_ctl flag_i (
            .clk    (clk),
            .rst    (rst),
            .tick   (tick_en),
            .match  (match_o[ch]),
            .ack    (irq_ack[ch]),
            .sw_clr (sw_clr[ch]),
            .flag_o (flag_o[ch])
        );
    end

    assign irq_o = flag_o & ien_q;

    logic unused_w;
    assign unused_w = ^{VAL_W};

endmodule

// File: rtl/cmpflag_unit_chk.sv
module cmpflag_unit_chk #(
    parameter int CNT_W  = 8,
    parameter int NUM_CH = 2
) (
    input logic                    clk,
    input logic                    rst,
    input logic [CNT_W-1:0]        cnt_in,
    input logic                    tick_en,
    input logic [NUM_CH-1:0]       cmp_wr,
    input logic [CNT_W-1:0]        cmp_wdata,
    input logic                    ien_wr,
    input logic [NUM_CH-1:0]       ien_wdata,
    input logic [NUM_CH-1:0]       irq_ack,
    input logic                    fclr_wr,
    input logic [NUM_CH-1:0]       fclr_wdata,
    input logic [NUM_CH*CNT_W-1:0] cmp_val_o,
    input logic [NUM_CH-1:0]       match_o,
    input logic [NUM_CH-1:0]       flag_o,
    input logic [NUM_CH-1:0]       irq_o
);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
        // R4
        flag_tick_chk: assert property (@(posedge clk) disable iff (rst)
            $rose(flag_o[g]) |-> $past(tick_en));

        // R8
        ack_clr_chk: assert property (@(posedge clk) disable iff (rst)
            (irq_ack[g] && !tick_en) |=> !flag_o[g]);

        // R9
        sw_clr_chk: assert property (@(posedge clk) disable iff (rst)
            (fclr_wr && fclr_wdata[g] && !tick_en) |=> !flag_o[g]);

        // R7
        irq_mask_chk: assert property (@(posedge clk) disable iff (rst)
            (ien_wr && !ien_wdata[g]) |=> !irq_o[g]);

        // R2
        cmp_load_chk: assert property (@(posedge clk) disable iff (rst)
            cmp_wr[g] |=> (cmp_val_o[g*CNT_W +: CNT_W] == $past(cmp_wdata)));

        // R3
        match_eq_chk: assert property (@(posedge clk) disable iff (rst)
            match_o[g] == (cnt_in == cmp_val_o[g*CNT_W +: CNT_W]));
    end

endmodule

bind cmpflag_unit cmpflag_unit_chk #(.CNT_W(CNT_W), .NUM_CH(NUM_CH)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .cnt_in     (cnt_in),
    .tick_en    (tick_en),
    .cmp_wr     (cmp_wr),
    .cmp_wdata  (cmp_wdata),
    .ien_wr     (ien_wr),
    .ien_wdata  (ien_wdata),
    .irq_ack    (irq_ack),
    .fclr_wr    (fclr_wr),
    .fclr_wdata (fclr_wdata),
    .cmp_val_o  (cmp_val_o),
    .match_o    (match_o),
    .flag_o     (flag_o),
    .irq_o      (irq_o)
);

// File: tb/cmpflag_unit_tb_top.sv
module cmpflag_unit_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  cnt_in = 8'hFF;
    logic        tick_en = 1'b0;
    logic [1:0]  cmp_wr = '0;
    logic [7:0]  cmp_wdata = '0;
    logic        ien_wr = 1'b0;
    logic [1:0]  ien_wdata = '0;
    logic [1:0]  irq_ack = '0;
    logic        fclr_wr = 1'b0;
    logic [1:0]  fclr_wdata = '0;
    logic [15:0] cmp_val_o;
    logic [1:0]  match_o;
    logic [1:0]  flag_o;
    logic [1:0]  irq_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cmpflag_unit dut_i (
        .clk(clk), .rst(rst), .cnt_in(cnt_in), .tick_en(tick_en),
        .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata), .ien_wr(ien_wr),
        .ien_wdata(ien_wdata), .irq_ack(irq_ack), .fclr_wr(fclr_wr),
        .fclr_wdata(fclr_wdata), .cmp_val_o(cmp_val_o), .match_o(match_o),
        .flag_o(flag_o), .irq_o(irq_o)
    );

    typedef struct packed {
        logic [1:0] cw;
        logic [7:0] wd;
        logic [7:0] cnt;
        logic       tk;
        logic [1:0] ack;
        logic       fw;
        logic [1:0] fd;
        logic       iw;
        logic [1:0] id;
        logic [1:0] em;
        logic [1:0] ef;
        logic [1:0] ei;
    } vec_t;

    // match is checked before the edge; flag and irq after it
    localparam vec_t VEC [0:17] = '{
        '{2'b01, 8'h10, 8'hFF, 1'b0, 2'b00, 1'b0, 2'b00, 1'b0, 2'b00, 2'b00, 2'b00, 2'b00}, // R2 load A
        '{2'b10, 8'h20, 8'h05, 1'b0, 2'b00, 1'b0, 2'b00, 1'b0, 2'b00, 2'b00, 2'b00, 2'b00}, // R2 load B
        '{2'b00, 8'h00, 8'h10, 1'b0, 2'b00, 1'b0, 2'b00, 1'b1, 2'b11, 2'b01, 2'b00, 2'b00}, // R3 A match, R7 enable
        '{2'b00, 8'h00, 8'h11, 1'b0, 2'b00, 1'b0, 2'b00, 1'b0, 2'b00, 2'b00, 2'b00, 2'b00}, // R6 no tick
        '{2'b00, 8'h00, 8'h11, 1'b1, 2'b00, 1'b0, 2'b00, 1'b0, 2'b00, 2'b00, 2'b01, 2'b01}, // R4 A set
        '{2'b00, 8'h00, 8'h20, 1'b1, 2'b00, 1'b0, 2'b00, 1'b0, 2'b00, 2'b10, 2'b01, 2'b01}, // R5 B match on tick
        '{2'b00, 8'h00, 8'h00, 1'b1, 2'b00, 1'b0, 2'b00, 1'b0, 2'b00, 2'b00, 2'b11, 2'b11}, // R5 B set next tick
        '{2'b00, 8'h00, 8'h00, 1'b0, 2'b00, 1'b1, 2'b00, 1'b0, 2'b00, 2'b00, 2'b11, 2'b11}, // R9 zero no effect
        '{2'b00, 8'h00, 8'h00, 1'b0, 2'b00, 1'b1, 2'b01, 1'b0, 2'b00, 2'b00, 2'b10, 2'b10}, // R9 R11 clear A
        '{2'b00, 8'h00, 8'h00, 1'b0, 2'b00, 1'b0, 2'b00, 1'b1, 2'b00, 2'b00, 2'b10, 2'b00}, // R7 mask
        '{2'b00, 8'h00, 8'h00, 1'b0, 2'b10, 1'b0, 2'b00, 1'b0, 2'b00, 2'b00, 2'b00, 2'b00}, // R8 ack B
        '{2'b00, 8'h00, 8'h10, 1'b0, 2'b00, 1'b0, 2'b00, 1'b0, 2'b00, 2'b01, 2'b00, 2'b00}, // R10 arm A
        '{2'b00, 8'h00, 8'h00, 1'b1, 2'b01, 1'b0, 2'b00, 1'b0, 2'b00, 2'b00, 2'b01, 2'b00}, // R10 set beats ack
        '{2'b00, 8'h00, 8'h00, 1'b0, 2'b00, 1'b0, 2'b00, 1'b1, 2'b01, 2'b00, 2'b01, 2'b01}, // R7 enable A
        '{2'b00, 8'h00, 8'h00, 1'b0, 2'b01, 1'b0, 2'b00, 1'b0, 2'b00, 2'b00, 2'b00, 2'b00}, // R8 ack A
        '{2'b11, 8'h33, 8'h33, 1'b0, 2'b00, 1'b0, 2'b00, 1'b0, 2'b00, 2'b00, 2'b00, 2'b00}, // R2 dual load
        '{2'b00, 8'h00, 8'h33, 1'b1, 2'b00, 1'b0, 2'b00, 1'b0, 2'b00, 2'b11, 2'b00, 2'b00}, // R5 both on tick
        '{2'b00, 8'h00, 8'h00, 1'b1, 2'b00, 1'b0, 2'b00, 1'b0, 2'b00, 2'b00, 2'b11, 2'b01}  // R4 R11 both set
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic idle();
        cmp_wr = '0; ien_wr = 1'b0; irq_ack = '0; fclr_wr = 1'b0;
        fclr_wdata = '0; tick_en = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk("R1", {16'h0, cmp_val_o}, 32'h0);
        chk("R1", {30'h0, flag_o}, 32'h0);
        chk("R1", {30'h0, irq_o}, 32'h0);
        rst = 1'b0;

        for (int i = 0; i < 18; i++) begin
            cmp_wr = VEC[i].cw; cmp_wdata = VEC[i].wd; cnt_in = VEC[i].cnt;
            tick_en = VEC[i].tk; irq_ack = VEC[i].ack; fclr_wr = VEC[i].fw;
            fclr_wdata = VEC[i].fd; ien_wr = VEC[i].iw; ien_wdata = VEC[i].id;
            #1;
            chk("R3", {30'h0, match_o}, {30'h0, VEC[i].em});
            @(posedge clk);
            @(negedge clk);
            chk("R4", {30'h0, flag_o}, {30'h0, VEC[i].ef});
            chk("R7", {30'h0, irq_o}, {30'h0, VEC[i].ei});
        end
        idle();
        // R2 both compare values loaded
        chk("R2", {16'h0, cmp_val_o}, 32'h3333);

        // R1 mid-run reset clears everything
        rst = 1'b1;
        cnt_in = 8'hFF;
        @(posedge clk);
        @(negedge clk);
        chk("R1", {16'h0, cmp_val_o}, 32'h0);
        chk("R1", {30'h0, flag_o}, 32'h0);
        rst = 1'b0;
        // R1 enables are zero: flags set but no irq
        cnt_in = 8'h00;
        @(posedge clk);
        @(negedge clk);
        tick_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        tick_en = 1'b0;
        chk("R1", {30'h0, flag_o}, 32'h3);
        chk("R1", {30'h0, irq_o}, 32'h0);
        // R9 software clear of both at once
        fclr_wr = 1'b1; fclr_wdata = 2'b11;
        @(posedge clk);
        @(negedge clk);
        idle();
        chk("R9", {30'h0, flag_o}, 32'h0);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                #(CLK_PERIOD * 100000);
                n_chk++;
                n_fail++;
                $display("FAIL watchdog act=hung exp=done");
            end
        join_any
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule